// File: doc/BRIEF.md
# Multi-Speed Transmit Clock-Enable and Forwarded-Clock Pattern Generator

This block sits beside a tri-speed Ethernet MAC whose transmit side always runs from one free-running 125 MHz clock. It adapts that single clock to 1000, 100 or 10 Mbps operation without creating any further clock. It gives the MAC a clock-enable pulse train; the MAC and its user logic move one data item on each enabled cycle and hold otherwise. It also drives the rising-edge and falling-edge data inputs of an output DDR cell, so that the forwarded transmit clock is built by the same kind of register, with the same delay, as the data and control pins.

All three outputs are registered in the one clock domain, so a single clock can feed any number of these generators. A two-bit select picks the rate. A change of select and a synchronous reset both restart the pattern from its first phase. The cycle in which the change is seen outputs a quiet state, and the cycle after it starts a fresh enable and a fresh high clock phase.

Top module: `rgtx_enable_gen`

## Requirements
- R1: Select encoding: `speed_sel` 2'b00 selects 10 Mbps, 2'b01 selects 100 Mbps, and 2'b10 or 2'b11 select 1000 Mbps.
- R2: At 1000 Mbps, every cycle outputs `tx_enable`=1, `clk_rise`=1, `clk_fall`=0.
- R3: At 100 Mbps, `tx_enable` is high for one cycle in every ten. The (`clk_rise`,`clk_fall`) pair runs through (1,1),(1,1),(1,0),(0,0),(0,0) and repeats every five cycles, giving 5 high and 5 low half-cycles per forwarded period.
- R4: At 10 Mbps, `tx_enable` is high for one cycle in every hundred. `clk_rise` and `clk_fall` are both 1 for 25 cycles, then both 0 for 25 cycles, and this repeats.
- R5: At 100 and 10 Mbps, each `tx_enable` pulse falls on the first cycle of a forwarded-clock high phase, on every second forwarded period. An enabled cycle always has `clk_rise`=1, and an enable pulse is never longer than one cycle.
- R6: When `speed_sel` differs from its value at the previous clock edge, the outputs registered at that edge are all 0. From the next edge on, the new pattern starts at its first phase, which is an enable cycle with `clk_rise`=1.
- R7: A synchronous active-high `rst` makes all outputs 0 at the next edge. The first edge with `rst` low produces the first phase of the selected pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running 125 MHz transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_sel | input | 2 | Line-rate select (R1 encoding) |
| tx_enable | output | 1 | Registered clock enable for the MAC transmit path |
| clk_rise | output | 1 | Rising-edge data of the forwarded-clock DDR cell |
| clk_fall | output | 1 | Falling-edge data of the forwarded-clock DDR cell |

## Verification
Some properties are checked on every cycle. The phase counter stays inside the selected half-period, the enable is a single-cycle pulse that lands only on a high clock phase, the 1000 Mbps output is held at its fixed level, and a select change or a reset is followed by a quiet cycle. Only the bench scenarios can show the exact 1:10 and 1:100 enable ratios, the 50% duty of the forwarded clock over long windows, and the correct restart after random dwell times at random speeds, including the 2'b11 code.

// File: rtl/rgtx_pkg.sv
package rgtx_pkg;

    typedef enum logic [1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10
    } speed_t;

    typedef struct packed {
        logic en;
        logic rise;
        logic fall;
    } txpat_t;

    localparam txpat_t PAT_IDLE = '{en: 1'b0, rise: 1'b0, fall: 1'b0};
    localparam txpat_t PAT_GIG  = '{en: 1'b1, rise: 1'b1, fall: 1'b0};

    // R1: bit 1 set means gigabit whatever bit 0 holds
    function automatic speed_t decode_speed(input logic [1:0] sel);
        if (sel[1])      return SPD_1000;
        else if (sel[0]) return SPD_100;
        else             return SPD_10;
    endfunction

endpackage

// File: rtl/rgtx_phase_ctr.sv
module rgtx_phase_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [CW-1:0] half,
    output logic [CW-1:0] sub,
    output logic          odd
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sub <= '0;
            odd <= 1'b0;
        end else if (sub >= half - ONE) begin
            sub <= '0;
            odd <= ~odd;
        end else begin
            sub <= sub + ONE;
        end
    end

    // R3 / R4: the position never leaves the current half-period
    assert_sub_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (sub < half));

    // R4: a completed half-period wraps to position zero
    assert_sub_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (!restart && (sub == half - ONE)) |=> (sub == '0));

endmodule

// File: rtl/rgtx_pattern_map.sv
module rgtx_pattern_map
    import rgtx_pkg::*;
#(
    parameter int CW = 6
) (
    input  speed_t        spd,
    input  logic [CW-1:0] sub,
    input  logic          odd,
    input  logic [CW-1:0] half,
    output txpat_t        pat
);
    logic [CW:0] pos_r;
    logic [CW:0] pos_f;
    logic [CW:0] lim;

    // half-cycle index of each DDR slot within one forwarded period
    assign pos_r = {sub, 1'b0};
    assign pos_f = {sub, 1'b1};
    assign lim   = {1'b0, half};

    always_comb begin
        if (spd == SPD_1000) begin
            pat = PAT_GIG;
        end else begin
            pat.en   = (sub == '0) && !odd;
            pat.rise = pos_r < lim;
            pat.fall = pos_f < lim;
        end
    end

endmodule

// File: rtl/rgtx_enable_gen.sv
module rgtx_enable_gen
    import rgtx_pkg::*;
#(
    parameter int DIV_100 = 10,
    parameter int DIV_10  = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] speed_sel,
    output logic       tx_enable,
    output logic       clk_rise,
    output logic       clk_fall
);
    localparam int HALF_100 = DIV_100 / 2;
    localparam int HALF_10  = DIV_10 / 2;
    localparam int CW       = $clog2(HALF_10 + 1);

    speed_t        spd;
    logic [1:0]    sel_q;
    logic          chg;
    logic [CW-1:0] half;
    logic [CW-1:0] sub;
    logic          odd;
    txpat_t        pat;
    txpat_t        pat_q;

    assign spd = decode_speed(speed_sel);
    assign chg = (speed_sel != sel_q);

    always_comb begin
        unique case (spd)
            SPD_10:  half = CW'(HALF_10);
            SPD_100: half = CW'(HALF_100);
            default: half = CW'(1);
        endcase
    end

    rgtx_phase_ctr #(.CW(CW)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .restart (chg),
        .half    (half),
        .sub     (sub),
        .odd     (odd)
    );

    rgtx_pattern_map #(.CW(CW)) u_map (
        .spd  (spd),
        .sub  (sub),
        .odd  (odd),
        .half (half),
        .pat  (pat)
    );

    always_ff @(posedge clk) begin
        sel_q <= speed_sel;
        if (rst || chg) pat_q <= PAT_IDLE;
        else            pat_q <= pat;
    end

    assign tx_enable = pat_q.en;
    assign clk_rise  = pat_q.rise;
    assign clk_fall  = pat_q.fall;

    // R2: steady gigabit select gives the fixed level
    assert_gig_level_R2: assert property (@(posedge clk) disable iff (rst)
        (!chg && speed_sel[1]) |=> (tx_enable && clk_rise && !clk_fall));

    // R5: enable only on a high phase, single cycle at the lower rates
    assert_en_on_high_R5: assert property (@(posedge clk) disable iff (rst)
        tx_enable |-> clk_rise);

    assert_en_single_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_enable && !speed_sel[1] && !chg) |=> !tx_enable);

    // R6: a select change yields a quiet cycle
    assert_change_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        chg |=> (!tx_enable && !clk_rise && !clk_fall));

    // R7: reset clears the outputs at the next edge
    assert_reset_quiet_R7: assert property (@(posedge clk)
        rst |=> (!tx_enable && !clk_rise && !clk_fall));

endmodule

// File: tb/test_rgtx_enable_gen.sv
module test_rgtx_enable_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed_sel = 2'b10;
    logic       tx_enable, clk_rise, clk_fall;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          done   = 0;

    // bench model state
    logic [1:0]  m_sel = 2'b10;
    int unsigned m_k   = 0;
    logic [2:0]  m_exp = 3'b000;

    always #10 clk = ~clk;

    rgtx_enable_gen i_rgtx_enable_gen (
        .clk       (clk),
        .rst       (rst),
        .speed_sel (speed_sel),
        .tx_enable (tx_enable),
        .clk_rise  (clk_rise),
        .clk_fall  (clk_fall)
    );

    function automatic int unsigned cyc_per_en(input logic [1:0] s);
        if (s[1])      return 1;
        else if (s[0]) return 10;
        else           return 100;
    endfunction

    // {en, rise, fall} for cycle k after restart
    function automatic logic [2:0] expect_pat(input logic [1:0] s, input int unsigned k);
        int unsigned per;
        int unsigned c;
        if (s[1]) return 3'b110;
        per = cyc_per_en(s) / 2;
        c   = k % per;
        return {(k == 0), (2 * c < per), (2 * c + 1 < per)};
    endfunction

    function automatic string tag_of(input logic [1:0] s);
        if (s[1])      return "R2";
        else if (s[0]) return "R3";
        else           return "R4";
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got {en,rise,fall}=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int unsigned act, input int unsigned exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic [1:0] s, input logic r);
        string tag;
        speed_sel = s;
        rst       = r;
        @(posedge clk);
        if (r) begin
            m_exp = 3'b000; m_k = 0; tag = "R7";
        end else if (s != m_sel) begin
            m_exp = 3'b000; m_k = 0; tag = "R6";
        end else begin
            m_exp = expect_pat(s, m_k);
            tag   = (m_k == 0) ? "R5" : tag_of(s);
            m_k   = (m_k + 1) % cyc_per_en(s);
        end
        m_sel = s;
        @(negedge clk);
        check(tag, {tx_enable, clk_rise, clk_fall}, m_exp);
    endtask

    // long window at one speed: counts ratios and duty
    task automatic window(input logic [1:0] s, input int unsigned len, input string tag);
        int unsigned ens = 0, halves = 0, bad_align = 0;
        step(s == 2'b00 ? 2'b01 : 2'b00, 1'b0);
        step(s, 1'b0);
        for (int i = 0; i < int'(len); i++) begin
            step(s, 1'b0);
            ens    += tx_enable;
            halves += clk_rise + clk_fall;
            if (tx_enable && !clk_rise) bad_align++;
        end
        check_int({tag, " enable count"}, ens, len / cyc_per_en(s));
        check_int({tag, " high half-cycles"}, halves, s[1] ? len : len);
        check_int("R5 enable on high phase", bad_align, 0);
    endtask

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        @(negedge clk);
        step(2'b10, 1'b1);
        step(2'b10, 1'b1);
        check("R7 reset state", {tx_enable, clk_rise, clk_fall}, 3'b000);

        // R7: first edge after release gives phase 0
        step(2'b01, 1'b1);
        step(2'b01, 1'b0);
        check("R7 first phase", {tx_enable, clk_rise, clk_fall}, 3'b111);

        // R3 directed sequence of one forwarded period
        step(2'b01, 1'b0); check("R3 phase1", {tx_enable, clk_rise, clk_fall}, 3'b011);
        step(2'b01, 1'b0); check("R3 phase2", {tx_enable, clk_rise, clk_fall}, 3'b010);
        step(2'b01, 1'b0); check("R3 phase3", {tx_enable, clk_rise, clk_fall}, 3'b000);

        // R6: change mid-pattern gives a quiet cycle then phase 0
        step(2'b00, 1'b0);
        check("R6 quiet", {tx_enable, clk_rise, clk_fall}, 3'b000);
        step(2'b00, 1'b0);
        check("R6 restart", {tx_enable, clk_rise, clk_fall}, 3'b111);

        // R1: code 2'b11 behaves as gigabit
        step(2'b11, 1'b0);
        step(2'b11, 1'b0);
        check("R1 code 11 gigabit", {tx_enable, clk_rise, clk_fall}, 3'b110);

        window(2'b10, 200,  "R2");
        window(2'b11, 100,  "R1");
        window(2'b01, 1000, "R3");
        window(2'b00, 2000, "R4");

        // random speed changes, dwell times and resets
        for (int seg = 0; seg < 40; seg++) begin
            logic [1:0] s = 2'($urandom_range(0, 3));
            int unsigned dwell = $urandom_range(1, 250);
            logic r = ($urandom_range(0, 9) == 0);
            if (r) step(s, 1'b1);
            for (int i = 0; i < int'(dwell); i++) step(s, 1'b0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule